// File: doc/BRIEF.md
# Two-Bank Memory Operation Sequencer

This block carries out one of four memory operations on two small on-chip banks once its operands are present at its inputs: read one word, write one word, copy one word to another address, or exchange the contents of two addresses. Each bank is synchronous, holds eight 4-bit words and has a single address port, one data input and its own write enable. The top bit of a 4-bit address picks the bank and the three lower bits pick the word inside it.

An operation starts with a one-cycle pulse on one of four start inputs. Read and write take their address and data from the processor-side operand inputs. Copy and exchange take two addresses from the transfer-side operand inputs. A sequencer then walks through the steps. Each step is one clock cycle and makes one memory access. The sequencer steers the address source, a data register and a temporary register. Each bank drives a display output that holds the word most recently read from it. A one-cycle `done` pulse marks the end of every operation.

Top module: `mem_ops_ctrl`

## Requirements
- R1: Address bit 3 selects the bank: 0 selects the low bank (addresses 0x0 to 0x7, shown on `disp_lo`) and 1 selects the high bank (0x8 to 0xF, shown on `disp_hi`). Bits 2:0 select the word.
- R2: A read pulse (`go_rd`) shows the word stored at `cpu_addr` on the display output of its bank. The operation takes one busy cycle, and the display is valid from the cycle in which `done` is high.
- R3: A write pulse (`go_wr`) stores `cpu_data` at `cpu_addr` in one busy cycle. No other word changes.
- R4: A copy pulse (`go_cp`) places the word at `dma_addr_a` into `dma_addr_b` in three busy cycles: read, capture into the data register, write. The source word is unchanged, and a copy from an address onto itself changes nothing.
- R5: An exchange pulse (`go_sw`) swaps the words at `dma_addr_a` and `dma_addr_b` in five busy cycles. This holds within one bank, across the two banks, and when both addresses are the same (no change). At most one bank access happens per cycle.
- R6: All operands are sampled in the cycle the start pulse is seen. Later changes to the operand inputs have no effect on the running operation.
- R7: `done` is high for exactly one cycle. This is the cycle after the final step: the second cycle after the start for read and write, the fourth for copy and the sixth for exchange. `done` is low at all other times.
- R8: Start pulses that arrive while an operation is running are ignored. The running operation keeps its timing and result, and memory and displays are not touched by the ignored request.
- R9: When several start pulses arrive in the same idle cycle, only one operation runs, chosen by the priority read, then write, then copy, then exchange.
- R10: After reset every word of both banks reads as zero, both displays show zero, and `done` is low.
- R11: The reads made inside copy and exchange also update the display of the bank they read; for an exchange within one bank, the display shows the second address's old word. Writes never change a display.
- R12: A start pulse given in the same cycle that `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| go_rd | input | 1 | Start pulse for read |
| go_wr | input | 1 | Start pulse for write |
| go_cp | input | 1 | Start pulse for copy |
| go_sw | input | 1 | Start pulse for exchange |
| cpu_addr | input | 4 | Address for read and write |
| cpu_data | input | 4 | Data for write |
| dma_addr_a | input | 4 | First address for copy and exchange |
| dma_addr_b | input | 4 | Second address for copy and exchange |
| disp_lo | output | 4 | Word last read from the low bank |
| disp_hi | output | 4 | Word last read from the high bank |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The end of one operation and the acceptance of the next can fall in the same cycle, because a new start pulse is accepted while `done` is high. The random sequence issues every operation immediately after the previous `done` and checks the exact cycle of each `done` pulse, along with displays and memory contents, against a bench model. A second overlap happens when a start arrives while the sequencer is busy. Random runs inject all four start pulses, with scrambled operands, at a random busy cycle. The check is that the running operation's timing, the memory and the displays match the model as if nothing had been requested.

// File: rtl/mem_ops_pkg.sv
package mem_ops_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_CP_RA,
    ST_CP_CAP,
    ST_CP_WB,
    ST_SW_RA,
    ST_SW_RB,
    ST_SW_CAPB,
    ST_SW_WA,
    ST_SW_WB
  } seq_state_e;

  // Step controls from the sequencer to the datapath
  typedef struct packed {
    logic ld_ops;    // sample operand inputs
    logic op_dma;    // first address from transfer side
    logic ld_d_cpu;  // data register <- cpu data
    logic rd_en;     // read access this cycle
    logic wr_en;     // write access this cycle
    logic sel_b;     // use second address
    logic ld_d_mem;  // data register <- read-back word
    logic ld_t;      // temporary register <- read-back word
    logic wsrc_t;    // write data from temporary register
  } seq_ctrl_t;

endpackage

// File: rtl/mo_rst_sync.sv
module mo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/mo_bank.sv
module mo_bank #(
  parameter int WORD_W = 4,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en) mem_q[idx] <= wdata;
      if (rd_en) rdata_q    <= mem_q[idx];
    end
  end

  assign rdata = rdata_q;

  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/mo_sequencer.sv
module mo_sequencer
  import mem_ops_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go_rd,
  input  logic      go_wr,
  input  logic      go_cp,
  input  logic      go_sw,
  output seq_ctrl_t ctrl,
  output logic      busy,
  output logic      done
);

  seq_state_e state_q, state_d;
  logic       fin;
  logic       done_q;

  always_comb begin
    state_d = state_q;
    ctrl    = '0;
    fin     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go_rd) begin
          ctrl.ld_ops = 1'b1;
          state_d     = ST_RD;
        end else if (go_wr) begin
          ctrl.ld_ops   = 1'b1;
          ctrl.ld_d_cpu = 1'b1;
          state_d       = ST_WR;
        end else if (go_cp) begin
          ctrl.ld_ops = 1'b1;
          ctrl.op_dma = 1'b1;
          state_d     = ST_CP_RA;
        end else if (go_sw) begin
          ctrl.ld_ops = 1'b1;
          ctrl.op_dma = 1'b1;
          state_d     = ST_SW_RA;
        end
      end
      ST_RD: begin
        ctrl.rd_en = 1'b1;
        fin        = 1'b1;
        state_d    = ST_IDLE;
      end
      ST_WR: begin
        ctrl.wr_en = 1'b1;
        fin        = 1'b1;
        state_d    = ST_IDLE;
      end
      ST_CP_RA: begin
        ctrl.rd_en = 1'b1;
        state_d    = ST_CP_CAP;
      end
      ST_CP_CAP: begin
        ctrl.ld_d_mem = 1'b1;
        state_d       = ST_CP_WB;
      end
      ST_CP_WB: begin
        ctrl.wr_en = 1'b1;
        ctrl.sel_b = 1'b1;
        fin        = 1'b1;
        state_d    = ST_IDLE;
      end
      ST_SW_RA: begin
        ctrl.rd_en = 1'b1;
        state_d    = ST_SW_RB;
      end
      ST_SW_RB: begin
        ctrl.rd_en    = 1'b1;
        ctrl.sel_b    = 1'b1;
        ctrl.ld_d_mem = 1'b1;
        state_d       = ST_SW_CAPB;
      end
      ST_SW_CAPB: begin
        ctrl.ld_t = 1'b1;
        state_d   = ST_SW_WA;
      end
      ST_SW_WA: begin
        ctrl.wr_en  = 1'b1;
        ctrl.wsrc_t = 1'b1;
        state_d     = ST_SW_WB;
      end
      ST_SW_WB: begin
        ctrl.wr_en = 1'b1;
        ctrl.sel_b = 1'b1;
        fin        = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R8
  entry_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {ST_RD, ST_WR, ST_CP_RA, ST_SW_RA}) |-> $past(state_q) == ST_IDLE);

endmodule

// File: rtl/mo_datapath.sv
module mo_datapath
  import mem_ops_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  seq_ctrl_t                    ctrl,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [WORD_W-1:0]            cpu_data,
  input  logic [ADDR_W-1:0]            dma_addr_a,
  input  logic [ADDR_W-1:0]            dma_addr_b,
  input  logic [1:0][WORD_W-1:0]       bank_rdata,
  output logic [1:0]                   bank_rd,
  output logic [1:0]                   bank_wr,
  output logic [ADDR_W-2:0]            bank_idx,
  output logic [WORD_W-1:0]            bank_wdata
);

  localparam int NB = 2;

  logic [ADDR_W-1:0] addr_a_q, addr_b_q;
  logic [WORD_W-1:0] dreg_q, treg_q;
  logic              rd_bank_q;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_bank;
  logic [WORD_W-1:0] rback;

  // Operand capture: first address comes from the selected side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_a_q <= '0;
      addr_b_q <= '0;
    end else if (ctrl.ld_ops) begin
      addr_a_q <= ctrl.op_dma ? dma_addr_a : cpu_addr;
      addr_b_q <= dma_addr_b;
    end
  end

  assign rback = bank_rdata[rd_bank_q];

  // Data and temporary holding registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg_q <= '0;
      treg_q <= '0;
    end else begin
      if (ctrl.ld_d_cpu)      dreg_q <= cpu_data;
      else if (ctrl.ld_d_mem) dreg_q <= rback;
      if (ctrl.ld_t)          treg_q <= rback;
    end
  end

  // Remember which bank the last read went to
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_bank_q <= 1'b0;
    else if (ctrl.rd_en) rd_bank_q <= cur_bank;
  end

  assign cur_addr   = ctrl.sel_b ? addr_b_q : addr_a_q;
  assign cur_bank   = cur_addr[ADDR_W-1];
  assign bank_idx   = cur_addr[ADDR_W-2:0];
  assign bank_wdata = ctrl.wsrc_t ? treg_q : dreg_q;

  for (genvar g = 0; g < NB; g++) begin : g_bank_sel
    assign bank_rd[g] = ctrl.rd_en && (cur_bank == 1'(g));
    assign bank_wr[g] = ctrl.wr_en && (cur_bank == 1'(g));
  end

  // R5
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bank_rd, bank_wr}));

  // R6
  ops_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.ld_ops |=> $stable(addr_a_q) && $stable(addr_b_q));

endmodule

// File: rtl/mem_ops_ctrl.sv
module mem_ops_ctrl
  import mem_ops_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int WORD_W     = 4,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_rd,
  input  logic              go_wr,
  input  logic              go_cp,
  input  logic              go_sw,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_data,
  input  logic [ADDR_W-1:0] dma_addr_a,
  input  logic [ADDR_W-1:0] dma_addr_b,
  output logic [WORD_W-1:0] disp_lo,
  output logic [WORD_W-1:0] disp_hi,
  output logic              done
);

  localparam int NB    = 2;
  localparam int IDX_W = ADDR_W - 1;

  logic                   rst_n_i;
  seq_ctrl_t              ctrl;
  logic                   busy;
  logic [NB-1:0][WORD_W-1:0] bank_rdata;
  logic [NB-1:0]          bank_rd, bank_wr;
  logic [IDX_W-1:0]       bank_idx;
  logic [WORD_W-1:0]      bank_wdata;

  mo_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_i)
  );

  mo_sequencer i_seq (
    .clk   (clk),
    .rst_n (rst_n_i),
    .go_rd (go_rd),
    .go_wr (go_wr),
    .go_cp (go_cp),
    .go_sw (go_sw),
    .ctrl  (ctrl),
    .busy  (busy),
    .done  (done)
  );

  mo_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_dp (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .ctrl       (ctrl),
    .cpu_addr   (cpu_addr),
    .cpu_data   (cpu_data),
    .dma_addr_a (dma_addr_a),
    .dma_addr_b (dma_addr_b),
    .bank_rdata (bank_rdata),
    .bank_rd    (bank_rd),
    .bank_wr    (bank_wr),
    .bank_idx   (bank_idx),
    .bank_wdata (bank_wdata)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    mo_bank #(.WORD_W(WORD_W), .IDX_W(IDX_W)) i_bank (
      .clk   (clk),
      .rst_n (rst_n_i),
      .rd_en (bank_rd[g]),
      .wr_en (bank_wr[g]),
      .idx   (bank_idx),
      .wdata (bank_wdata),
      .rdata (bank_rdata[g])
    );
  end

  assign disp_lo = bank_rdata[0];
  assign disp_hi = bank_rdata[1];

  // R11
  disp_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !busy |=> $stable({disp_lo, disp_hi}));

endmodule

// File: tb/test_mem_ops_ctrl.sv
module test_mem_ops_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       go_rd, go_wr, go_cp, go_sw;
  logic [3:0] cpu_addr, cpu_data, dma_addr_a, dma_addr_b;
  logic [3:0] disp_lo, disp_hi;
  logic       done;

  int checks = 0;
  int errors = 0;

  logic [3:0] mdl_mem  [16];
  logic [3:0] mdl_disp [2];

  always #5 clk = ~clk;

  mem_ops_ctrl i_mem_ops_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_rd      (go_rd),
    .go_wr      (go_wr),
    .go_cp      (go_cp),
    .go_sw      (go_sw),
    .cpu_addr   (cpu_addr),
    .cpu_data   (cpu_data),
    .dma_addr_a (dma_addr_a),
    .dma_addr_b (dma_addr_b),
    .disp_lo    (disp_lo),
    .disp_hi    (disp_hi),
    .done       (done)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int busy_cycles(input int op);
    case (op)
      0, 1:    return 1;
      2:       return 3;
      default: return 5;
    endcase
  endfunction

  // Model: op 0 read, 1 write, 2 copy, 3 exchange
  task automatic model_apply(input int op, input logic [3:0] ca, input logic [3:0] cd,
                             input logic [3:0] da, input logic [3:0] db);
    logic [3:0] t;
    case (op)
      0: mdl_disp[ca[3]] = mdl_mem[ca];
      1: mdl_mem[ca] = cd;
      2: begin
        mdl_disp[da[3]] = mdl_mem[da];
        mdl_mem[db]     = mdl_mem[da];
      end
      default: begin
        mdl_disp[da[3]] = mdl_mem[da];
        mdl_disp[db[3]] = mdl_mem[db];
        t           = mdl_mem[da];
        mdl_mem[da] = mdl_mem[db];
        mdl_mem[db] = t;
      end
    endcase
  endtask

  // Starts at a negedge, returns at the negedge where done is high
  task automatic run_op(input string tag, input logic r, input logic w, input logic c,
                        input logic s, input logic [3:0] ca, input logic [3:0] cd,
                        input logic [3:0] da, input logic [3:0] db, input int intr_k);
    int op;
    int n;
    op = r ? 0 : w ? 1 : c ? 2 : 3;
    n  = busy_cycles(op);
    model_apply(op, ca, cd, da, db);
    go_rd = r; go_wr = w; go_cp = c; go_sw = s;
    cpu_addr = ca; cpu_data = cd; dma_addr_a = da; dma_addr_b = db;
    for (int k = 1; k <= n + 1; k++) begin
      @(negedge clk);
      go_rd = 1'b0; go_wr = 1'b0; go_cp = 1'b0; go_sw = 1'b0;
      cpu_addr = 4'($urandom); cpu_data = 4'($urandom);
      dma_addr_a = 4'($urandom); dma_addr_b = 4'($urandom);
      if (k == intr_k && k <= n) begin
        go_rd = 1'b1; go_wr = 1'b1; go_cp = 1'b1; go_sw = 1'b1;
      end
      chk({tag, " done timing"}, {3'b0, done}, {3'b0, (k == n + 1)});
    end
    chk({tag, " disp_lo"}, disp_lo, mdl_disp[0]);
    chk({tag, " disp_hi"}, disp_hi, mdl_disp[1]);
  endtask

  task automatic read_mem(input string tag, input logic [3:0] a);
    run_op(tag, 1'b1, 1'b0, 1'b0, 1'b0, a, 4'h0, 4'h0, 4'h0, 0);
    chk({tag, " word"}, a[3] ? disp_hi : disp_lo, mdl_mem[a]);
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 16; a++) read_mem(tag, 4'(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) mdl_mem[i] = 4'h0;
    mdl_disp[0] = 4'h0;
    mdl_disp[1] = 4'h0;
    rst_n = 1'b0;
    go_rd = 1'b0; go_wr = 1'b0; go_cp = 1'b0; go_sw = 1'b0;
    cpu_addr = '0; cpu_data = '0; dma_addr_a = '0; dma_addr_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk("R10 done after reset", {3'b0, done}, 4'h0);
    chk("R10 disp_lo after reset", disp_lo, 4'h0);
    chk("R10 disp_hi after reset", disp_hi, 4'h0);
    sweep("R10 reset contents");

    // R3 R1 writes into both banks
    run_op("R3 write low", 1'b0, 1'b1, 1'b0, 1'b0, 4'h3, 4'hA, 4'h0, 4'h0, 0);
    run_op("R3 write high", 1'b0, 1'b1, 1'b0, 1'b0, 4'hB, 4'h5, 4'h0, 4'h0, 0);
    run_op("R3 write low2", 1'b0, 1'b1, 1'b0, 1'b0, 4'h1, 4'h7, 4'h0, 4'h0, 0);
    run_op("R3 write low3", 1'b0, 1'b1, 1'b0, 1'b0, 4'h2, 4'hE, 4'h0, 4'h0, 0);
    read_mem("R1 bank low", 4'h3);
    read_mem("R1 bank high", 4'hB);
    read_mem("R2 unwritten alias", 4'h8);

    // R4 copy across banks and onto itself
    run_op("R4 copy cross", 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 4'h0, 4'h3, 4'hC, 0);
    run_op("R4 copy self", 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 4'h0, 4'hB, 4'hB, 0);

    // R5 R11 exchange across banks, within a bank, onto itself
    run_op("R5 swap cross", 1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 4'h0, 4'h3, 4'hB, 0);
    run_op("R11 swap same bank", 1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 4'h0, 4'h1, 4'h2, 0);
    run_op("R5 swap self", 1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 4'h0, 4'hC, 4'hC, 0);
    sweep("R5 after swaps");

    // R9 simultaneous starts
    run_op("R9 rd over wr", 1'b1, 1'b1, 1'b0, 1'b0, 4'h9, 4'h6, 4'h0, 4'h0, 0);
    run_op("R9 wr over cp", 1'b0, 1'b1, 1'b1, 1'b0, 4'h9, 4'h6, 4'h9, 4'h4, 0);
    run_op("R9 cp over sw", 1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 4'h0, 4'h9, 4'h4, 0);
    run_op("R9 all four", 1'b1, 1'b1, 1'b1, 1'b1, 4'h4, 4'h1, 4'h2, 4'h3, 0);
    sweep("R9 contents");

    // R8 starts during busy, R6 operand scrambling
    run_op("R8 swap intruded", 1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 4'h0, 4'h9, 4'h1, 3);
    run_op("R8 copy intruded", 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 4'h0, 4'h4, 4'hF, 1);
    run_op("R6 write scrambled", 1'b0, 1'b1, 1'b0, 1'b0, 4'h6, 4'hD, 4'h0, 4'h0, 1);
    sweep("R8 contents");

    // R12 back-to-back mixed traffic with random intrusions
    for (int i = 0; i < 150; i++) begin
      logic [3:0] mask;
      int op;
      int ik;
      mask = 4'($urandom);
      if (mask == 4'h0 || ($urandom % 4) != 0) mask = 4'(1 << ($urandom % 4));
      op = mask[0] ? 0 : mask[1] ? 1 : mask[2] ? 2 : 3;
      ik = (($urandom % 3) == 0) ? 1 + int'($urandom % busy_cycles(op)) : 0;
      run_op("R12 random", mask[0], mask[1], mask[2], mask[3],
             4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), ik);
    end
    sweep("R6 final contents");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule